// File: doc/BRIEF.md
# Value-Checked In-Order Load Queue

This block holds in-flight loads in a plain ring of slots, ordered by program order, with no address matching of any kind. Dispatch allocates a slot for each load and is told its slot number. When the load first executes, the execution pipeline writes the address, the access size, the returned value and two hazard flags into that slot. One flag says an older store address was still unknown. The other says a coherence invalidation arrived while the load was in flight.

At the head of the queue, a load with neither flag set retires as soon as commit says it may. A flagged load is sent to the data cache a second time, once commit says it may proceed, and only one such request is outstanding at a time. The returned value is compared with the recorded one over the bytes the access size covers. Equal values retire the load. Different values raise a violation that names the load's tag, and the load and everything behind it are discarded. An external flush trims the queue back to a given slot. Two counters report how many second accesses and how many violations occurred.

Top module: `value_replay_lq`

## Requirements
- R1: After reset the queue is empty: head_valid, retire_valid, viol_valid and rp_req_valid are 0, alloc_ready is 1, alloc_slot is 0 and both counters are 0.
- R2: A load is accepted when alloc_valid and alloc_ready are both high. It goes to the slot shown on alloc_slot, which then advances by one modulo DEPTH. alloc_ready is low while DEPTH loads are held, and also in any cycle with flush_valid or viol_valid high.
- R3: A head load that has executed with both ex_store_unknown and ex_inval_seen low retires in the same cycle that commit_ready is high: retire_valid pulses with retire_tag equal to its tag, and no cache request is made.
- R4: A head load that has not executed neither retires nor makes a cache request, whatever commit_ready does.
- R5: A head load that executed with ex_store_unknown or ex_inval_seen high, in a cycle with commit_ready high, raises rp_req_valid for exactly that one cycle, carrying its recorded address and size. No further request is made until rp_rsp_valid is seen.
- R6: When rp_rsp_valid arrives with a value equal to the recorded one, the head load retires in that same cycle.
- R7: When rp_rsp_valid arrives with a different value, viol_valid pulses in that cycle with viol_tag equal to the head tag, and no retirement occurs. From the next cycle the queue is empty and alloc_slot equals the discarded head's slot.
- R8: The value compare covers only the low bytes selected by the size code: 0 selects bits 7:0, 1 selects 15:0, 2 selects 31:0 and 3 selects 63:0, each limited to DW bits. Differences above the selected bits do not count.
- R9: flush_valid keeps the live loads from the head up to and including flush_slot, which must name a live slot, and discards every younger one. On the next cycle alloc_slot is flush_slot plus one modulo DEPTH.
- R10: replay_cnt increases by one for every rp_req_valid pulse and viol_cnt by one for every viol_valid pulse, wrapping at CW bits.
- R11: Loads retire in allocation order, and head_tag always shows the tag of the oldest live load.
- R12: An execution write-back to a slot that holds no live load has no effect, and a newly allocated load always starts as not executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Dispatch offers a load |
| alloc_tag | input | TW | Instruction tag of the offered load |
| alloc_ready | output | 1 | Queue can take a load this cycle |
| alloc_slot | output | IW | Slot the next accepted load receives |
| ex_valid | input | 1 | First-execution write-back |
| ex_slot | input | IW | Slot being written back |
| ex_addr | input | AW | Load address |
| ex_size | input | 2 | Access size code |
| ex_data | input | DW | Value returned by the first execution |
| ex_store_unknown | input | 1 | An older store address was unresolved at execution |
| ex_inval_seen | input | 1 | An invalidation was observed while in flight |
| commit_ready | input | 1 | Commit permits the head load to proceed |
| head_valid | output | 1 | Queue holds at least one load |
| head_tag | output | TW | Tag of the oldest load |
| retire_valid | output | 1 | Head load retires this cycle |
| retire_tag | output | TW | Tag of the retiring load |
| rp_req_valid | output | 1 | Second cache access request |
| rp_req_addr | output | AW | Address of that request |
| rp_req_size | output | 2 | Size code of that request |
| rp_rsp_valid | input | 1 | Cache response to the request |
| rp_rsp_data | input | DW | Value returned by the second access |
| viol_valid | output | 1 | Ordering violation detected |
| viol_tag | output | TW | Tag of the violating load |
| flush_valid | input | 1 | Trim the queue |
| flush_slot | input | IW | Youngest slot to keep |
| replay_cnt | output | CW | Number of second accesses |
| viol_cnt | output | CW | Number of violations |

## Verification
The bench builds the queue with DEPTH 4, AW 12, DW 32, TW 6 and CW 8. The four-slot ring puts the full condition, pointer wrap and a flush that crosses the wrap point within a handful of loads. The 32-bit data path lets byte and halfword compares ignore corrupted upper bits while word and doubleword compares see the whole value. An 8-bit counter width makes the replay counter wrap during the long mixed-traffic run.

// File: rtl/vrlq_pkg.sv
package vrlq_pkg;

  typedef enum logic [0:0] {
    HD_IDLE = 1'b0,
    HD_WAIT = 1'b1
  } head_state_e;

  // Bytes covered by a size code, as a bit mask over a 64-bit value.
  function automatic logic [63:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 64'h0000_0000_0000_00FF;
      2'd1:    return 64'h0000_0000_0000_FFFF;
      2'd2:    return 64'h0000_0000_FFFF_FFFF;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

  function automatic logic value_equal(input logic [63:0] a,
                                       input logic [63:0] b,
                                       input logic [1:0]  sz);
    return ((a ^ b) & size_mask(sz)) == 64'd0;
  endfunction

  // The filter: a load needs a second access only under a known hazard.
  function automatic logic replay_needed(input logic store_unknown,
                                         input logic inval_seen);
    return store_unknown | inval_seen;
  endfunction

endpackage

// File: rtl/lq_slots.sv
module lq_slots #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int TW    = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int CNTW = IW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_fire,
  input  logic [TW-1:0]   alloc_tag,
  input  logic            ex_valid,
  input  logic [IW-1:0]   ex_slot,
  input  logic [AW-1:0]   ex_addr,
  input  logic [1:0]      ex_size,
  input  logic [DW-1:0]   ex_data,
  input  logic            ex_flag,
  input  logic            retire_fire,
  input  logic            viol_fire,
  input  logic            flush_valid,
  input  logic [IW-1:0]   flush_slot,
  output logic [IW-1:0]   tail_slot,
  output logic [CNTW-1:0] occupancy,
  output logic            head_live,
  output logic            head_exec,
  output logic            head_nr,
  output logic [AW-1:0]   head_addr,
  output logic [1:0]      head_size,
  output logic [DW-1:0]   head_data,
  output logic [TW-1:0]   head_tag
);

  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

  function automatic logic [IW-1:0] ring_dist(input logic [IW-1:0] a,
                                              input logic [IW-1:0] b);
    return a - b;
  endfunction

  logic [IW-1:0]   head_q, tail_q;
  logic [CNTW-1:0] cnt_q;
  logic [DEPTH-1:0] live_q, done_q, rpl_q;
  logic [AW-1:0]   addr_q [DEPTH];
  logic [1:0]      size_q [DEPTH];
  logic [DW-1:0]   data_q [DEPTH];
  logic [TW-1:0]   tag_q  [DEPTH];

  // Named per-slot events
  logic [DEPTH-1:0] alloc_hit, ex_hit, cut_hit, ret_hit;
  logic [IW-1:0]    keep_dist;
  logic [CNTW-1:0]  cnt_after_flush;

  assign keep_dist       = ring_dist(flush_slot, head_q);
  assign cnt_after_flush = flush_valid ? (CNTW'(keep_dist) + CNTW'(1)) : cnt_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam logic [IW-1:0] SLOT = IW'(i);
    assign alloc_hit[i] = alloc_fire && (tail_q == SLOT);
    assign ex_hit[i]    = ex_valid && (ex_slot == SLOT) && live_q[i];
    assign cut_hit[i]   = flush_valid && (ring_dist(SLOT, head_q) > keep_dist);
    assign ret_hit[i]   = retire_fire && (head_q == SLOT);
  end

  // Pointers and occupancy
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (viol_fire) begin
      tail_q <= head_q;
      cnt_q  <= '0;
    end else begin
      head_q <= head_q + IW'(retire_fire);
      tail_q <= (flush_valid ? (flush_slot + IW'(1)) : tail_q) + IW'(alloc_fire);
      cnt_q  <= cnt_after_flush - CNTW'(retire_fire) + CNTW'(alloc_fire);
    end
  end

  // Per-slot state bits
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
      done_q <= '0;
      rpl_q  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (viol_fire)                   live_q[i] <= 1'b0;
        else if (alloc_hit[i])           live_q[i] <= 1'b1;
        else if (cut_hit[i] || ret_hit[i]) live_q[i] <= 1'b0;

        if (alloc_hit[i]) begin
          done_q[i] <= 1'b0;
          rpl_q[i]  <= 1'b0;
        end else if (ex_hit[i]) begin
          done_q[i] <= 1'b1;
          rpl_q[i]  <= ex_flag;
        end
      end
    end
  end

  // Payload, no reset needed
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc_hit[i]) tag_q[i] <= alloc_tag;
      if (ex_hit[i]) begin
        addr_q[i] <= ex_addr;
        size_q[i] <= ex_size;
        data_q[i] <= ex_data;
      end
    end
  end

  assign tail_slot = tail_q;
  assign occupancy = cnt_q;
  assign head_live = live_q[head_q];
  assign head_exec = done_q[head_q];
  assign head_nr   = rpl_q[head_q];
  assign head_addr = addr_q[head_q];
  assign head_size = size_q[head_q];
  assign head_data = data_q[head_q];
  assign head_tag  = tag_q[head_q];

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> (cnt_q < FULL_CNT));

  // R2
  live_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    CNTW'($countones(live_q)) == cnt_q);

  // R7
  viol_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_fire |=> (cnt_q == '0) && !head_live);

  // R9
  flush_keeps_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && !viol_fire && !retire_fire && head_live) |=> head_live);

endmodule

// File: rtl/lq_head_ctrl.sv
module lq_head_ctrl
  import vrlq_pkg::*;
#(
  parameter int DW = 64,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          head_live,
  input  logic          head_exec,
  input  logic          head_nr,
  input  logic [1:0]    head_size,
  input  logic [DW-1:0] head_data,
  input  logic          commit_ready,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          req_fire,
  output logic          retire_fire,
  output logic          viol_fire,
  output logic [CW-1:0] replay_cnt,
  output logic [CW-1:0] viol_cnt
);

  head_state_e state_q, state_d;
  logic        cmp_equal;
  logic        head_ready;
  logic [CW-1:0] rp_cnt_q, vl_cnt_q;

  assign cmp_equal  = value_equal(64'(head_data), 64'(rsp_data), head_size);
  assign head_ready = head_live && head_exec && commit_ready;

  always_comb begin
    state_d     = state_q;
    req_fire    = 1'b0;
    retire_fire = 1'b0;
    viol_fire   = 1'b0;
    case (state_q)
      HD_IDLE: begin
        if (head_ready) begin
          if (head_nr) begin
            req_fire = 1'b1;
            state_d  = HD_WAIT;
          end else begin
            retire_fire = 1'b1;
          end
        end
      end
      HD_WAIT: begin
        if (rsp_valid) begin
          state_d = HD_IDLE;
          if (cmp_equal) retire_fire = 1'b1;
          else           viol_fire   = 1'b1;
        end
      end
      default: state_d = HD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= HD_IDLE;
      rp_cnt_q <= '0;
      vl_cnt_q <= '0;
    end else begin
      state_q  <= state_d;
      rp_cnt_q <= rp_cnt_q + CW'(req_fire);
      vl_cnt_q <= vl_cnt_q + CW'(viol_fire);
    end
  end

  assign replay_cnt = rp_cnt_q;
  assign viol_cnt   = vl_cnt_q;

  // R5
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_fire);

  // R5
  req_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |-> (head_nr && head_exec && commit_ready));

  // R3
  exempt_no_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_fire && !rsp_valid) |-> !head_nr);

  // R4
  no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (head_live && !head_exec) |-> (!retire_fire && !req_fire));

  // R7
  retire_viol_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(retire_fire && viol_fire));

  // R10
  replay_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> (replay_cnt == $past(replay_cnt) + CW'(1)));

  // R10
  viol_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_fire |=> (viol_cnt == $past(viol_cnt) + CW'(1)));

endmodule

// File: rtl/value_replay_lq.sv
module value_replay_lq
  import vrlq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int TW    = 8,
  parameter int CW    = 16,
  localparam int IW   = $clog2(DEPTH),
  localparam int CNTW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  input  logic [TW-1:0] alloc_tag,
  output logic          alloc_ready,
  output logic [IW-1:0] alloc_slot,
  input  logic          ex_valid,
  input  logic [IW-1:0] ex_slot,
  input  logic [AW-1:0] ex_addr,
  input  logic [1:0]    ex_size,
  input  logic [DW-1:0] ex_data,
  input  logic          ex_store_unknown,
  input  logic          ex_inval_seen,
  input  logic          commit_ready,
  output logic          head_valid,
  output logic [TW-1:0] head_tag,
  output logic          retire_valid,
  output logic [TW-1:0] retire_tag,
  output logic          rp_req_valid,
  output logic [AW-1:0] rp_req_addr,
  output logic [1:0]    rp_req_size,
  input  logic          rp_rsp_valid,
  input  logic [DW-1:0] rp_rsp_data,
  output logic          viol_valid,
  output logic [TW-1:0] viol_tag,
  input  logic          flush_valid,
  input  logic [IW-1:0] flush_slot,
  output logic [CW-1:0] replay_cnt,
  output logic [CW-1:0] viol_cnt
);

  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

  logic            alloc_fire, ex_flag;
  logic            retire_fire, viol_fire, req_fire;
  logic [CNTW-1:0] occupancy;
  logic            head_live, head_exec, head_nr;
  logic [AW-1:0]   head_addr;
  logic [1:0]      head_size;
  logic [DW-1:0]   head_data;
  logic [TW-1:0]   head_tag_w;

  assign alloc_ready = (occupancy != FULL_CNT) && !flush_valid && !viol_fire;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign ex_flag     = replay_needed(ex_store_unknown, ex_inval_seen);

  lq_slots #(
    .DEPTH(DEPTH), .AW(AW), .DW(DW), .TW(TW)
  ) u_slots (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_fire  (alloc_fire),
    .alloc_tag   (alloc_tag),
    .ex_valid    (ex_valid),
    .ex_slot     (ex_slot),
    .ex_addr     (ex_addr),
    .ex_size     (ex_size),
    .ex_data     (ex_data),
    .ex_flag     (ex_flag),
    .retire_fire (retire_fire),
    .viol_fire   (viol_fire),
    .flush_valid (flush_valid),
    .flush_slot  (flush_slot),
    .tail_slot   (alloc_slot),
    .occupancy   (occupancy),
    .head_live   (head_live),
    .head_exec   (head_exec),
    .head_nr     (head_nr),
    .head_addr   (head_addr),
    .head_size   (head_size),
    .head_data   (head_data),
    .head_tag    (head_tag_w)
  );

  lq_head_ctrl #(
    .DW(DW), .CW(CW)
  ) u_head (
    .clk          (clk),
    .rst_n        (rst_n),
    .head_live    (head_live),
    .head_exec    (head_exec),
    .head_nr      (head_nr),
    .head_size    (head_size),
    .head_data    (head_data),
    .commit_ready (commit_ready),
    .rsp_valid    (rp_rsp_valid),
    .rsp_data     (rp_rsp_data),
    .req_fire     (req_fire),
    .retire_fire  (retire_fire),
    .viol_fire    (viol_fire),
    .replay_cnt   (replay_cnt),
    .viol_cnt     (viol_cnt)
  );

  assign head_valid   = head_live;
  assign head_tag     = head_tag_w;
  assign retire_valid = retire_fire;
  assign retire_tag   = head_tag_w;
  assign viol_valid   = viol_fire;
  assign viol_tag     = head_tag_w;
  assign rp_req_valid = req_fire;
  assign rp_req_addr  = head_addr;
  assign rp_req_size  = head_size;

  // R11
  retire_from_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid || viol_valid || rp_req_valid) |-> head_valid);

  // R2
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == FULL_CNT) |-> !alloc_ready);

endmodule

// File: tb/sim_value_replay_lq.sv
`timescale 1ns/1ps
module sim_value_replay_lq;
  localparam int DEPTH = 4;
  localparam int AW    = 12;
  localparam int DW    = 32;
  localparam int TW    = 6;
  localparam int CW    = 8;
  localparam int IW    = 2;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic          alloc_valid;
  logic [TW-1:0] alloc_tag;
  logic          alloc_ready;
  logic [IW-1:0] alloc_slot;
  logic          ex_valid;
  logic [IW-1:0] ex_slot;
  logic [AW-1:0] ex_addr;
  logic [1:0]    ex_size;
  logic [DW-1:0] ex_data;
  logic          ex_store_unknown, ex_inval_seen;
  logic          commit_ready;
  logic          head_valid;
  logic [TW-1:0] head_tag;
  logic          retire_valid;
  logic [TW-1:0] retire_tag;
  logic          rp_req_valid;
  logic [AW-1:0] rp_req_addr;
  logic [1:0]    rp_req_size;
  logic          rp_rsp_valid;
  logic [DW-1:0] rp_rsp_data;
  logic          viol_valid;
  logic [TW-1:0] viol_tag;
  logic          flush_valid;
  logic [IW-1:0] flush_slot;
  logic [CW-1:0] replay_cnt, viol_cnt;

  value_replay_lq #(
    .DEPTH(DEPTH), .AW(AW), .DW(DW), .TW(TW), .CW(CW)
  ) u0 (.*);

  int checks = 0;
  int fails  = 0;

  task automatic cmp(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference model: an ordered list of live loads
  typedef struct {
    int          slot;
    int          tag;
    bit          ex;
    bit          nr;
    int          addr;
    int          sz;
    int unsigned data;
  } ld_t;

  ld_t q[$];
  int  m_head = 0;
  bit  m_wait = 0;
  int  m_rp = 0;
  int  m_vc = 0;
  bit  flushed_last = 0;
  bit  obs_retire, obs_viol, obs_req;

  function automatic bit same_val(input int unsigned a, input int unsigned b, input int sz);
    int bits;
    bits = 8 << sz;
    if (bits >= 32) return a == b;
    return ((a ^ b) & ((32'd1 << bits) - 1)) == 0;
  endfunction

  task automatic idle();
    alloc_valid = 0; alloc_tag = '0;
    ex_valid = 0; ex_slot = '0; ex_addr = '0; ex_size = '0; ex_data = '0;
    ex_store_unknown = 0; ex_inval_seen = 0;
    commit_ready = 0;
    rp_rsp_valid = 0; rp_rsp_data = '0;
    flush_valid = 0; flush_slot = '0;
  endtask

  task automatic step();
    bit hv, e_req, e_ret, e_viol, e_ar;
    int e_slot, keep;
    ld_t h;
    string rl;
    #1;
    hv = q.size() > 0;
    if (hv) h = q[0];
    e_viol = hv && m_wait && rp_rsp_valid && !same_val(h.data, rp_rsp_data, h.sz);
    e_ret  = hv && ((!m_wait && h.ex && !h.nr && commit_ready) ||
                    (m_wait && rp_rsp_valid && same_val(h.data, rp_rsp_data, h.sz)));
    e_req  = hv && !m_wait && h.ex && h.nr && commit_ready;
    e_ar   = (q.size() < DEPTH) && !flush_valid && !e_viol;
    e_slot = (m_head + q.size()) % DEPTH;

    rl = m_wait ? "R6" : ((hv && !h.ex) ? "R4" : "R3");
    cmp("R2", "alloc_ready", alloc_ready, e_ar);
    cmp(flushed_last ? "R9" : "R2", "alloc_slot", alloc_slot, e_slot);
    cmp("R11", "head_valid", head_valid, hv);
    if (hv) cmp("R11", "head_tag", head_tag, h.tag);
    cmp(rl, "retire_valid", retire_valid, e_ret);
    if (e_ret) cmp("R11", "retire_tag", retire_tag, h.tag);
    cmp("R5", "rp_req_valid", rp_req_valid, e_req);
    if (e_req) begin
      cmp("R5", "rp_req_addr", rp_req_addr, h.addr);
      cmp("R5", "rp_req_size", rp_req_size, h.sz);
    end
    cmp("R7", "viol_valid", viol_valid, e_viol);
    if (e_viol) cmp("R7", "viol_tag", viol_tag, h.tag);
    cmp("R10", "replay_cnt", replay_cnt, m_rp % 256);
    cmp("R10", "viol_cnt", viol_cnt, m_vc % 256);
    obs_retire = retire_valid;
    obs_viol   = viol_valid;
    obs_req    = rp_req_valid;

    @(posedge clk);
    if (ex_valid)
      foreach (q[k])
        if (q[k].slot == int'(ex_slot)) begin
          q[k].ex   = 1;
          q[k].nr   = ex_store_unknown | ex_inval_seen;
          q[k].addr = int'(ex_addr);
          q[k].sz   = int'(ex_size);
          q[k].data = ex_data;
        end
    if (e_req) begin m_wait = 1; m_rp++; end
    else if (m_wait && rp_rsp_valid) m_wait = 0;
    if (e_viol) begin
      q.delete();
      m_vc++;
    end else begin
      if (flush_valid) begin
        keep = ((int'(flush_slot) - m_head + DEPTH) % DEPTH) + 1;
        while (q.size() > keep) void'(q.pop_back());
      end
      if (e_ret) begin
        void'(q.pop_front());
        m_head = (m_head + 1) % DEPTH;
      end
      if (alloc_valid && e_ar) begin
        ld_t n;
        n.slot = e_slot; n.tag = int'(alloc_tag);
        n.ex = 0; n.nr = 0; n.addr = 0; n.sz = 0; n.data = 0;
        q.push_back(n);
      end
    end
    flushed_last = flush_valid;
    @(negedge clk);
    idle();
  endtask

  task automatic do_alloc(input int tag);
    alloc_valid = 1; alloc_tag = TW'(tag); step();
  endtask

  task automatic do_exec(input int slot, input int addr, input int sz,
                         input int unsigned data, input bit unk, input bit inv);
    ex_valid = 1; ex_slot = IW'(slot); ex_addr = AW'(addr); ex_size = 2'(sz);
    ex_data = data; ex_store_unknown = unk; ex_inval_seen = inv; step();
  endtask

  task automatic do_commit();
    commit_ready = 1; step();
  endtask

  task automatic do_rsp(input int unsigned data);
    rp_rsp_valid = 1; rp_rsp_data = data; step();
  endtask

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    cmp("R1", "head_valid", head_valid, 0);
    cmp("R1", "alloc_ready", alloc_ready, 1);
    cmp("R1", "alloc_slot", alloc_slot, 0);
    cmp("R1", "retire_valid", retire_valid, 0);
    cmp("R1", "viol_valid", viol_valid, 0);
    cmp("R1", "rp_req_valid", rp_req_valid, 0);
    cmp("R1", "counters", {replay_cnt, viol_cnt}, 0);
    step();

    // R2 fill to full, then an offer is refused
    do_alloc(10); do_alloc(11); do_alloc(12); do_alloc(13);
    do_alloc(14);
    cmp("R2", "full refuses", alloc_ready, 0);

    // R4 head not executed
    do_commit();
    cmp("R4", "no retire before exec", obs_retire, 0);

    // R3 exempt load retires at once
    do_exec(0, 'h100, 2, 32'hAAAA5555, 0, 0);
    do_commit();
    cmp("R3", "exempt retire", obs_retire, 1);
    cmp("R3", "exempt no request", obs_req, 0);

    // R6 flagged load, equal value after a wait
    do_exec(1, 'h104, 2, 32'h12345678, 1, 0);
    do_commit();
    cmp("R5", "request issued", obs_req, 1);
    step(); commit_ready = 1; step();
    cmp("R5", "single outstanding", obs_req, 0);
    do_rsp(32'h12345678);
    cmp("R6", "equal retire", obs_retire, 1);

    // R8 byte compare ignores upper bits
    do_exec(2, 'h108, 0, 32'h000000AB, 0, 1);
    do_commit();
    do_rsp(32'hFFFFFFAB);
    cmp("R8", "byte mask match", obs_retire, 1);
    cmp("R8", "byte mask no violation", obs_viol, 0);

    // R7 halfword mismatch
    do_exec(3, 'h10C, 1, 32'h00001234, 1, 0);
    do_commit();
    do_rsp(32'h00001235);
    cmp("R7", "violation raised", obs_viol, 1);
    #1;
    cmp("R7", "queue empty", head_valid, 0);
    cmp("R7", "tail at head slot", alloc_slot, 3);

    // R12 write-back to a dead slot has no effect
    do_exec(1, 'h200, 2, 32'h0, 0, 0);
    do_alloc(20); do_alloc(21); do_alloc(22);
    do_commit();
    cmp("R12", "fresh load not executed", obs_retire, 0);
    do_exec(3, 'h204, 2, 32'h1, 0, 0);
    do_commit();
    do_exec(0, 'h208, 2, 32'h2, 0, 0);
    do_commit();
    do_commit();
    cmp("R12", "dead-slot write ignored", obs_retire, 0);

    // R9 flush across the wrap
    do_alloc(23); do_alloc(24); do_alloc(25);
    flush_valid = 1; flush_slot = 2; alloc_valid = 1; alloc_tag = 6'd30; step();
    #1;
    cmp("R9", "tail after flush", alloc_slot, 3);
    cmp("R9", "head survives", head_tag, 22);

    // Mixed traffic
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if ($urandom % 3 == 0) begin alloc_valid = 1; alloc_tag = TW'($urandom); end
      if (q.size() > 0 && $urandom % 2 == 0) begin
        int k;
        k = int'($urandom % q.size());
        if (!(m_wait && k == 0)) begin
          ex_valid = 1; ex_slot = IW'(q[k].slot); ex_addr = AW'($urandom);
          ex_size = 2'($urandom); ex_data = $urandom;
          ex_store_unknown = ($urandom % 4 == 0); ex_inval_seen = ($urandom % 8 == 0);
        end
      end else if ($urandom % 10 == 0) begin
        int s;
        s = int'($urandom % DEPTH);
        if (!(m_wait && s == m_head)) begin
          ex_valid = 1; ex_slot = IW'(s); ex_data = $urandom; ex_size = 2'($urandom);
        end
      end
      commit_ready = $urandom % 2;
      if (m_wait && $urandom % 3 == 0) begin
        rp_rsp_valid = 1;
        rp_rsp_data  = ($urandom % 5 == 0) ? (q[0].data ^ (32'd1 << ($urandom % 32))) : q[0].data;
      end
      if (q.size() > 0 && $urandom % 40 == 0) begin
        flush_valid = 1;
        flush_slot  = IW'(q[$urandom % q.size()].slot);
      end
      step();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule